// File: doc/BRIEF.md
# Game Frame Preprocessing Pipeline

This block turns raw console video into input frames for a convolutional network, streaming the whole way. Each incoming pixel is a 7-bit colour index delivered in raster order, with a valid strobe and a start-of-frame marker on the first pixel. The index is mapped to an 8-bit luminance value. That value is pooled against the same position of the previous frame by taking the larger of the two, so a sprite drawn only on alternate frames still shows up. The pooled image is reduced to an OUT_W×OUT_H grid by bilinear interpolation. The last four reduced frames are then delivered as one four-channel pixel group per output position.

The input side has no ready signal and is never stalled. The output side is a valid/ready stream. A short FIFO between the resize stage and the channel stage absorbs brief stalls. The intended configuration is a 160×210 input reduced to 84×84, set through the parameters. The default parameters are a smaller geometry with the same structure.

Top module: `frame_prep`

## Requirements
- R1: An index `i` is converted as follows. Red is `i[6:4]*36`, green is `i[3:2]*85` and blue is `i[1:0]*85`. Luminance is `(77*R + 150*G + 29*B + 128) >> 8`. For example, index 0x2D gives 181 and index 0x7F gives 254.
- R2: Each pooled pixel is the maximum of the current luminance and the luminance stored at the same position from the previous frame. The first frame after reset is pooled against zero.
- R3: Output column `c` uses source position `xs = c*SX`, where `SX = floor(IN_W*256/OUT_W)`. Output row `r` uses `ys = r*SY`, where `SY = floor(IN_H*256/OUT_H)`. The four neighbours are at `(xs>>8, ys>>8)` plus one in each direction, with weights `fx = xs & 255` and `fy = ys & 255`. The value is `((p00*(256-fx)+p01*fx)*(256-fy) + (p10*(256-fx)+p11*fx)*fy + 32768) >> 16`, saturated to 255.
- R4: Every input frame yields exactly OUT_W*OUT_H output groups, in raster order.
- R5: `out_data[7:0]` carries the newest frame. Bits `[15:8]`, `[23:16]` and `[31:24]` carry the frames one, two and three back. A channel whose frame does not exist yet since reset reads zero.
- R6: `out_done` is high for exactly the one cycle after the last group of a frame is accepted, and at no other time.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R8: During reset and immediately after it, `out_valid` and `out_done` are low.
- R9: No input pixel is lost under backpressure, provided the FIFO between the resize and channel stages never has to accept a push while it is full.
- R10: A pixel with `pix_sof` high is taken as position (0,0), even if the previous frame was cut short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | An input pixel is present this cycle |
| pix_sof | input | 1 | Marks the first pixel of a frame |
| pix_idx | input | 7 | Colour index of the pixel |
| out_valid | output | 1 | A pixel group is available |
| out_ready | input | 1 | Downstream accepts the group |
| out_data | output | 32 | Four 8-bit channels, newest frame in the lowest byte |
| out_done | output | 1 | One-cycle pulse after the last group of a frame |

## Verification
The overflow assertion assumes the consumer drains faster than the resize stage produces during an output row. The bench keeps within this by holding `out_ready` high three cycles in four on average and by inserting occasional idle cycles in the input stream. The resize assertion assumes that frames arrive whole, in raster order, with `pix_sof` on the first pixel. The one deliberately truncated sequence is a short run of pixels that ends on row 0, where no output is produced, and the next frame starts with `pix_sof`.

// File: rtl/fp_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the frame preprocessing pipeline.
// Assumes 7-bit colour indices; the palette is computed, not stored.
package fp_pkg;
    localparam int PIX_W = 8;
    localparam int CHANNELS = 4;

    // Map a colour index to BT.601-weighted 8-bit luminance.
    function automatic logic [7:0] idx_to_luma(input logic [6:0] idx);
        int r;
        int g;
        int b;
        int acc;
        r   = int'(idx[6:4]) * 36;
        g   = int'(idx[3:2]) * 85;
        b   = int'(idx[1:0]) * 85;
        acc = (77 * r + 150 * g + 29 * b + 128) >> 8;
        return 8'(acc);
    endfunction
endpackage

// File: rtl/fp_pool.sv
`timescale 1ns/1ps
// Converts indices to luminance and pools each pixel against the previous
// frame with a per-pixel maximum. Tracks the raster position itself.
// Assumes raster-ordered input with the start marker on the first pixel.
module fp_pool #(
    parameter int IN_W = 40,
    parameter int IN_H = 30,
    localparam int XW = $clog2(IN_W),
    localparam int YW = $clog2(IN_H),
    localparam int AW = $clog2(IN_W * IN_H)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic          pix_sof,
    input  logic [6:0]    pix_idx,
    output logic          pl_valid,
    output logic [7:0]    pl_pix,
    output logic [XW-1:0] pl_x,
    output logic [YW-1:0] pl_y
);
    logic [7:0]    prev_mem [IN_W*IN_H];
    logic [XW-1:0] cnt_x, pos_x;
    logic [YW-1:0] cnt_y, pos_y;
    logic [AW-1:0] addr;
    logic [7:0]    luma, old_luma, pooled;
    logic          first_frame;

    // Position of this pixel, luminance and pooled value.
    always_comb begin
        pos_x    = pix_sof ? '0 : cnt_x;
        pos_y    = pix_sof ? '0 : cnt_y;
        addr     = AW'(int'(pos_y) * IN_W + int'(pos_x));
        luma     = fp_pkg::idx_to_luma(pix_idx);
        old_luma = first_frame ? 8'd0 : prev_mem[addr];
        pooled   = (luma > old_luma) ? luma : old_luma;
    end

    // Store this frame's luminance for pooling the next frame.
    always_ff @(posedge clk) begin
        if (pix_valid) prev_mem[addr] <= luma;
    end

    // Raster counters, first-frame flag and the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_x       <= '0;
            cnt_y       <= '0;
            first_frame <= 1'b1;
            pl_valid    <= 1'b0;
            pl_pix      <= '0;
            pl_x        <= '0;
            pl_y        <= '0;
        end else begin
            pl_valid <= pix_valid;
            if (pix_valid) begin
                pl_pix <= pooled;
                pl_x   <= pos_x;
                pl_y   <= pos_y;
                if (pos_x == XW'(IN_W - 1)) begin
                    cnt_x <= '0;
                    if (pos_y == YW'(IN_H - 1)) begin
                        cnt_y       <= '0;
                        first_frame <= 1'b0;
                    end else begin
                        cnt_y <= pos_y + 1'b1;
                    end
                end else begin
                    cnt_x <= pos_x + 1'b1;
                    cnt_y <= pos_y;
                end
            end
        end
    end

    // A start marker always restarts at the origin (R10).
    assert_sof_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_sof |=> pl_valid && pl_x == '0 && pl_y == '0);
endmodule

// File: rtl/fp_resize.sv
`timescale 1ns/1ps
// Streaming bilinear reduction. It keeps one line of pooled pixels. An output
// is emitted when the pixel right and below its top-left neighbour arrives.
// Assumes IN_W > OUT_W and IN_H > OUT_H, so at most one output per input.
module fp_resize #(
    parameter int IN_W  = 40,
    parameter int IN_H  = 30,
    parameter int OUT_W = 21,
    parameter int OUT_H = 16,
    localparam int XW  = $clog2(IN_W),
    localparam int YW  = $clog2(IN_H),
    localparam int SX  = (IN_W * 256) / OUT_W,
    localparam int SY  = (IN_H * 256) / OUT_H,
    localparam int CW  = XW + 9,
    localparam int RW  = YW + 9,
    localparam int OCW = $clog2(OUT_W + 1),
    localparam int ORW = $clog2(OUT_H + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pl_valid,
    input  logic [7:0]    pl_pix,
    input  logic [XW-1:0] pl_x,
    input  logic [YW-1:0] pl_y,
    output logic          rs_valid,
    output logic [7:0]    rs_pix
);
    logic [7:0]     lb [IN_W];
    logic [7:0]     up, up_prev, cur_prev;
    logic [CW-1:0]  col_acc;
    logic [RW-1:0]  row_acc;
    logic [OCW-1:0] out_col;
    logic [ORW-1:0] out_row;
    logic           col_hit, row_hit;
    logic [7:0]     fx, fy;
    logic [8:0]     wx, wy;
    logic [16:0]    top_mix, bot_mix;
    logic [24:0]    blend;
    logic [7:0]     result;

    // Hit detection and the bilinear arithmetic.
    always_comb begin
        up      = lb[pl_x];
        fx      = col_acc[7:0];
        fy      = row_acc[7:0];
        wx      = 9'd256 - {1'b0, fx};
        wy      = 9'd256 - {1'b0, fy};
        col_hit = pl_valid && (out_col < OCW'(OUT_W))
                  && ({1'b0, pl_x} == col_acc[CW-1:8] + 1'b1);
        row_hit = (out_row < ORW'(OUT_H))
                  && ({1'b0, pl_y} == row_acc[RW-1:8] + 1'b1);
        top_mix = 17'(int'(up_prev) * int'(wx) + int'(up) * int'(fx));
        bot_mix = 17'(int'(cur_prev) * int'(wx) + int'(pl_pix) * int'(fx));
        blend   = 25'(int'(top_mix) * int'(wy) + int'(bot_mix) * int'(fy) + 32768);
        result  = blend[24] ? 8'hFF : blend[23:16];
    end

    // Line store: the pixel above for the next row.
    always_ff @(posedge clk) begin
        if (pl_valid) lb[pl_x] <= pl_pix;
    end

    // Neighbour registers, position accumulators and the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_prev  <= '0;
            cur_prev <= '0;
            col_acc  <= '0;
            row_acc  <= '0;
            out_col  <= '0;
            out_row  <= '0;
            rs_valid <= 1'b0;
            rs_pix   <= '0;
        end else begin
            rs_valid <= col_hit && row_hit;
            if (col_hit && row_hit) rs_pix <= result;
            if (pl_valid) begin
                up_prev  <= up;
                cur_prev <= pl_pix;
                if (pl_x == '0) begin
                    col_acc <= '0;
                    out_col <= '0;
                    if (pl_y == '0) begin
                        row_acc <= '0;
                        out_row <= '0;
                    end
                end else if (col_hit) begin
                    col_acc <= col_acc + CW'(SX);
                    out_col <= out_col + 1'b1;
                end
                if (pl_x == XW'(IN_W - 1) && row_hit) begin
                    row_acc <= row_acc + RW'(SY);
                    out_row <= out_row + 1'b1;
                end
            end
        end
    end

    // Outputs need two lines and two columns of history (R3).
    assert_two_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> $past(pl_valid) && $past(pl_y) != '0 && $past(pl_x) != '0);
endmodule

// File: rtl/fp_fifo.sv
`timescale 1ns/1ps
// Small elastic buffer between the resize and channel stages.
// Assumes the producer never pushes into a full buffer without a pop.
module fp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    logic [W-1:0]    mem [DEPTH];
    logic [PW-1:0]   wp, rp;
    logic [CNTW-1:0] cnt;

    // Head of the queue and the empty flag.
    always_comb begin
        dout  = mem[rp];
        empty = (cnt == '0);
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CNTW'(push) - CNTW'(pop);
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt != CNTW'(DEPTH)) || pop);
    assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/fp_stack.sv
`timescale 1ns/1ps
// Combines the newest reduced pixel with the same position of the three
// earlier frames. It drives the output handshake and the frame-done pulse.
// Assumes each frame delivers exactly OUT_W*OUT_H pixels.
module fp_stack #(
    parameter int OUT_W = 21,
    parameter int OUT_H = 16,
    localparam int N  = OUT_W * OUT_H,
    localparam int KW = $clog2(N)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        head_valid,
    input  logic [7:0]  head_pix,
    output logic        pop,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        out_done
);
    logic [7:0]    h1 [N];
    logic [7:0]    h2 [N];
    logic [7:0]    h3 [N];
    logic [KW-1:0] k;
    logic [1:0]    filled;
    logic          fire;
    logic [7:0]    ch1, ch2, ch3;

    // Handshake and channel assembly with zero fill.
    always_comb begin
        out_valid = head_valid;
        fire      = out_valid && out_ready;
        pop       = fire;
        ch1       = (filled != 2'd0) ? h1[k] : 8'd0;
        ch2       = (filled >= 2'd2) ? h2[k] : 8'd0;
        ch3       = (filled == 2'd3) ? h3[k] : 8'd0;
        out_data  = {ch3, ch2, ch1, head_pix};
    end

    // Age the history at this position on every accepted group.
    always_ff @(posedge clk) begin
        if (fire) begin
            h3[k] <= h2[k];
            h2[k] <= h1[k];
            h1[k] <= head_pix;
        end
    end

    // Position within the frame, frames seen, and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k        <= '0;
            filled   <= '0;
            out_done <= 1'b0;
        end else begin
            out_done <= fire && (k == KW'(N - 1));
            if (fire) begin
                if (k == KW'(N - 1)) begin
                    k <= '0;
                    if (filled != 2'd3) filled <= filled + 1'b1;
                end else begin
                    k <= k + 1'b1;
                end
            end
        end
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);
endmodule

// File: rtl/frame_prep.sv
`timescale 1ns/1ps
// Top of the frame preprocessing pipeline:
// pooling -> bilinear reduction -> elastic buffer -> four-frame channel stack.
// Assumes the input never needs to stall; backpressure is absorbed by the FIFO.
module frame_prep #(
    parameter int IN_W       = 40,
    parameter int IN_H       = 30,
    parameter int OUT_W      = 21,
    parameter int OUT_H      = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pix_valid,
    input  logic        pix_sof,
    input  logic [6:0]  pix_idx,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        out_done
);
    localparam int XW = $clog2(IN_W);
    localparam int YW = $clog2(IN_H);

    logic          pl_valid, rs_valid, fifo_empty, fifo_pop;
    logic [7:0]    pl_pix, rs_pix, fifo_head;
    logic [XW-1:0] pl_x;
    logic [YW-1:0] pl_y;

    fp_pool #(.IN_W(IN_W), .IN_H(IN_H)) u_pool (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .pix_idx(pix_idx), .pl_valid(pl_valid), .pl_pix(pl_pix),
        .pl_x(pl_x), .pl_y(pl_y));

    fp_resize #(.IN_W(IN_W), .IN_H(IN_H), .OUT_W(OUT_W), .OUT_H(OUT_H)) u_resize (
        .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_pix(pl_pix),
        .pl_x(pl_x), .pl_y(pl_y), .rs_valid(rs_valid), .rs_pix(rs_pix));

    fp_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(rs_valid), .din(rs_pix),
        .pop(fifo_pop), .dout(fifo_head), .empty(fifo_empty));

    fp_stack #(.OUT_W(OUT_W), .OUT_H(OUT_H)) u_stack (
        .clk(clk), .rst_n(rst_n), .head_valid(!fifo_empty), .head_pix(fifo_head),
        .pop(fifo_pop), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_done(out_done));
endmodule

// File: tb/frame_prep_test.sv
`timescale 1ns/1ps
module frame_prep_test;
    localparam int IN_W = 40, IN_H = 30, OUT_W = 21, OUT_H = 16;
    localparam int NP = IN_W * IN_H, N = OUT_W * OUT_H, NF = 6, NJ = 7;
    localparam int SX = (IN_W * 256) / OUT_W, SY = (IN_H * 256) / OUT_H;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pix_valid = 1'b0, pix_sof = 1'b0, out_ready = 1'b0;
    logic [6:0] pix_idx = '0;
    logic out_valid, out_done;
    logic [31:0] out_data;

    frame_prep uut (.clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .pix_idx(pix_idx), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_done(out_done));

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    logic [6:0]  frames [NF][NP];
    logic [6:0]  junk [NJ];
    logic [7:0]  prev_l [NP];
    logic [7:0]  pooled_b [NP];
    logic [7:0]  rs_ref [NF][N];
    logic [31:0] exp_g [NF][N];
    int of = 0, ok = 0, dones = 0, groups = 0;
    bit expect_done = 0, held = 0;
    logic [31:0] held_data;

    task automatic check(input bit cond, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] luma_ref(input int idx);
        int r, g, b;
        r = (idx >> 4) * 36;
        g = ((idx >> 2) & 3) * 85;
        b = (idx & 3) * 85;
        return 8'((77 * r + 150 * g + 29 * b + 128) >> 8);
    endfunction

    // Model one frame: pooling (R2), reduction (R3), channel stack (R5).
    task automatic model_frame(input int f);
        for (int p = 0; p < NP; p++) begin
            logic [7:0] l;
            l = luma_ref(int'(frames[f][p]));
            pooled_b[p] = (l > prev_l[p]) ? l : prev_l[p];
            prev_l[p] = l;
        end
        for (int r = 0; r < OUT_H; r++) begin
            for (int c = 0; c < OUT_W; c++) begin
                int xs, ys, x0, y0, fx, fy, a, b, cc, d, v;
                xs = c * SX; ys = r * SY;
                x0 = xs >> 8; y0 = ys >> 8; fx = xs & 255; fy = ys & 255;
                a = pooled_b[y0 * IN_W + x0];       b = pooled_b[y0 * IN_W + x0 + 1];
                cc = pooled_b[(y0 + 1) * IN_W + x0]; d = pooled_b[(y0 + 1) * IN_W + x0 + 1];
                v = ((a * (256 - fx) + b * fx) * (256 - fy)
                     + (cc * (256 - fx) + d * fx) * fy + 32768) >> 16;
                if (v > 255) v = 255;
                rs_ref[f][r * OUT_W + c] = 8'(v);
            end
        end
        for (int q = 0; q < N; q++) begin
            exp_g[f][q] = {24'd0, rs_ref[f][q]};
            if (f >= 1) exp_g[f][q][15:8]  = rs_ref[f-1][q];
            if (f >= 2) exp_g[f][q][23:16] = rs_ref[f-2][q];
            if (f >= 3) exp_g[f][q][31:24] = rs_ref[f-3][q];
        end
    endtask

    task automatic send_pixel(input logic [6:0] idx, input bit sof);
        @(negedge clk);
        if (($urandom % 5) == 0) begin
            pix_valid = 1'b0;
            @(negedge clk);
        end
        pix_valid = 1'b1; pix_sof = sof; pix_idx = idx;
    endtask

    // Output monitor; ready is decided at the negedge before each edge.
    initial begin
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (held) begin
                check(out_valid && out_data == held_data, "R7 hold", out_data, held_data);
                held = 0;
            end
            if (expect_done) begin
                check(out_done === 1'b1, "R6 done pulse", 32'(out_done), 32'd1);
                expect_done = 0;
                if (out_done) dones++;
            end else begin
                check(out_done === 1'b0, "R6 no stray done", 32'(out_done), 32'd0);
            end
            out_ready = (($urandom % 4) != 0);
            if (out_valid && out_ready && of < NF) begin
                string t0;
                case (of)
                    0: t0 = "R2 first frame";   2: t0 = "R2 max pooling";
                    3: t0 = "R1 luma";          4: t0 = "R10 sof restart";
                    default: t0 = "R3 bilinear";
                endcase
                check(out_data[7:0] == exp_g[of][ok][7:0], t0, {24'd0, out_data[7:0]},
                      {24'd0, exp_g[of][ok][7:0]});
                check(out_data[31:8] == exp_g[of][ok][31:8], "R5 channels",
                      {8'd0, out_data[31:8]}, {8'd0, exp_g[of][ok][31:8]});
                if (of == 2) check(out_data[7:0] == 8'd254, "R2 literal", 32'(out_data[7:0]), 32'd254);
                if (of == 3) check(out_data[7:0] == 8'd181, "R1 literal", 32'(out_data[7:0]), 32'd181);
                if (of == 0) check(out_data[31:8] == 24'd0, "R5 zero fill", 32'(out_data[31:8]), 32'd0);
                groups++;
                if (ok == N - 1) begin
                    ok = 0; of++; expect_done = 1;
                end else begin
                    ok++;
                end
            end else if (out_valid && !out_ready) begin
                held = 1; held_data = out_data;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < NP; p++) begin
            prev_l[p] = '0;
            frames[0][p] = 7'($urandom % 128);
            frames[1][p] = 7'h7F;
            frames[2][p] = 7'h00;
            frames[3][p] = 7'h2D;
            frames[4][p] = 7'($urandom % 128);
            frames[5][p] = 7'($urandom % 128);
        end
        for (int j = 0; j < NJ; j++) junk[j] = 7'($urandom % 128);
        for (int f = 0; f < NF; f++) begin
            if (f == 4) for (int j = 0; j < NJ; j++) prev_l[j] = luma_ref(int'(junk[j]));
            model_frame(f);
        end

        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && out_done === 1'b0, "R8 in reset",
              {30'd0, out_valid, out_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && out_done === 1'b0, "R8 after reset",
              {30'd0, out_valid, out_done}, 32'd0);

        for (int f = 0; f < NF; f++) begin
            if (f == 4) begin
                // Truncated partial frame; the next start marker must restart (R10).
                for (int j = 0; j < NJ; j++) send_pixel(junk[j], j == 0);
            end
            for (int p = 0; p < NP; p++) send_pixel(frames[f][p], p == 0);
        end
        @(negedge clk);
        pix_valid = 1'b0; pix_sof = 1'b0;

        for (int w = 0; w < 20000 && !(of == NF && !expect_done); w++) @(posedge clk);
        if (of != NF || expect_done) begin
            errors++; checks++;
            $display("FAIL watchdog R4: actual %0d frames expected %0d", of, NF);
        end
        repeat (2) @(negedge clk);
        check(groups == NF * N, "R4 group count R9", 32'(groups), 32'(NF * N));
        check(dones == NF, "R6 done count", 32'(dones), 32'(NF));
        check(out_valid === 1'b0, "R9 drained", 32'(out_valid), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule